// File: doc/BRIEF.md
# Multi-Slope Run-Up Charge Balancer

This block sequences the run-up phase of a multi-slope integrating converter. After a start pulse it keeps the unknown input connected to the integrator for a fixed number of periods, each a fixed number of clocks long. In every period it switches in exactly one of two references, positive or negative. The choice is driven by a comparator that watches the integrator output, so the integrator stays inside its rails however long the run-up lasts.

The block counts the periods spent on each reference. When the last period ends it reports the signed balance (negative-reference periods minus positive-reference periods) together with a one-cycle done pulse. This balance is the coarse conversion result, and its resolution grows with the number of periods. Whatever charge is left on the integrator after run-up belongs to a later run-down or residue stage and is not handled here.

Top module: `runup_balancer`

## Requirements
- R1: After reset, `in_conn`, `ref_pos`, `ref_neg` and `done` are low, and `np_cnt`, `nn_cnt` and `result` are zero.
- R2: A start pulse taken while idle raises `in_conn` from the next cycle for exactly NUM_PERIODS × L clocks. L is `period_len` sampled in the start cycle, and a value of 0 is treated as 1. Later changes to `period_len` have no effect on the run.
- R3: While `in_conn` is high exactly one of `ref_pos`/`ref_neg` is high. While it is low, both are low.
- R4: The reference for period 0 follows `comp` sampled in the start cycle. The reference for period k+1 follows `comp` sampled on the last clock of period k. `comp`=1 selects `ref_neg` and `comp`=0 selects `ref_pos`. `comp` at any other clock has no effect.
- R5: The reference selection holds for all clocks of a period and changes only at period boundaries.
- R6: `np_cnt` counts completed periods that used `ref_pos`, and `nn_cnt` counts those that used `ref_neg`. Both update at each period boundary, and their sum equals the number of completed periods. At the end of the run this sum is NUM_PERIODS.
- R7: In the cycle after the last clock of the final period, `done` is high for exactly one cycle. In that same cycle `result` = `nn_cnt` − `np_cnt` as a two's-complement value of CNT_W+1 bits. `result` then holds until the next run completes.
- R8: A start pulse while `in_conn` is high is ignored. The run's length, selections and counts are unchanged.
- R9: A new run clears `np_cnt` and `nn_cnt` to zero from the cycle after its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run-up (ignored while busy) |
| period_len | input | LEN_W | Clocks per period, sampled at start (0 acts as 1) |
| comp | input | 1 | Comparator: 1 = integrator above threshold |
| in_conn | output | 1 | Connect the unknown input to the integrator |
| ref_pos | output | 1 | Switch in the positive reference |
| ref_neg | output | 1 | Switch in the negative reference |
| np_cnt | output | CNT_W | Completed positive-reference periods |
| nn_cnt | output | CNT_W | Completed negative-reference periods |
| result | output | CNT_W+1 | Signed balance nn − np of the last completed run |
| done | output | 1 | One-cycle pulse when run-up completes |

## Verification
The bench holds `comp` at the opposite of the wanted value on every clock of a period except the last. A design that sampled the comparator at the wrong clock would therefore pick the wrong reference and give a wrong balance. Patterns that are all-positive, all-negative and alternating drive the result to both extremes and to zero. A design with an off-by-one in the period or clock counters would show a run that is too long or too short, or a done pulse in the wrong cycle. A period length of 0 and a change to `period_len` in mid-run expose a length register that is missing or not clamped. A start pulse in mid-run would restart or corrupt the tallies in a design that does not block it while busy.

// File: rtl/runup_pkg.sv
package runup_pkg;

  // Clamp a requested period length to at least one clock.
  function automatic logic [7:0] eff_len8(input logic [7:0] len);
    return (len == 8'd0) ? 8'd1 : len;
  endfunction

  // Signed balance of negative against positive periods.
  function automatic int balance(input int npos, input int nneg);
    return nneg - npos;
  endfunction

endpackage

// File: rtl/runup_period_timer.sv
module runup_period_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [LEN_W-1:0] len_in,
  output logic             period_end
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] clk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      clk_cnt <= '0;
    end else if (load) begin
      len_q   <= (len_in == '0) ? LEN_W'(1) : len_in;
      clk_cnt <= '0;
    end else if (run) begin
      clk_cnt <= period_end ? '0 : clk_cnt + 1'b1;
    end
  end

  assign period_end = run && (clk_cnt == len_q - 1'b1);
endmodule

// File: rtl/runup_ref_select.sv
module runup_ref_select (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic period_end,
  input  logic comp,
  output logic sel_neg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sel_neg <= 1'b0;
    else if (load || period_end) sel_neg <= comp;
  end
endmodule

// File: rtl/runup_tally.sv
module runup_tally #(
  parameter int NUM_PERIODS = 16,
  parameter int CNT_W       = $clog2(NUM_PERIODS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    period_end,
  input  logic                    sel_neg,
  output logic [CNT_W-1:0]        np_cnt,
  output logic [CNT_W-1:0]        nn_cnt,
  output logic                    last_period,
  output logic                    done,
  output logic signed [CNT_W:0]   result
);
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] np_next;
  logic [CNT_W-1:0] nn_next;

  assign last_period = (per_cnt == CNT_W'(NUM_PERIODS - 1));
  assign np_next     = np_cnt + CNT_W'(!sel_neg);
  assign nn_next     = nn_cnt + CNT_W'(sel_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      np_cnt  <= '0;
      nn_cnt  <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= period_end && last_period;
      if (load) begin
        per_cnt <= '0;
        np_cnt  <= '0;
        nn_cnt  <= '0;
      end else if (period_end) begin
        per_cnt <= per_cnt + 1'b1;
        np_cnt  <= np_next;
        nn_cnt  <= nn_next;
        if (last_period)
          result <= (CNT_W+1)'(runup_pkg::balance(int'(np_next), int'(nn_next)));
      end
    end
  end
endmodule

// File: rtl/runup_balancer.sv
module runup_balancer #(
  parameter int NUM_PERIODS = 16,
  parameter int LEN_W       = 8,
  parameter int CNT_W       = $clog2(NUM_PERIODS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEN_W-1:0]      period_len,
  input  logic                  comp,
  output logic                  in_conn,
  output logic                  ref_pos,
  output logic                  ref_neg,
  output logic [CNT_W-1:0]      np_cnt,
  output logic [CNT_W-1:0]      nn_cnt,
  output logic signed [CNT_W:0] result,
  output logic                  done
);
  logic busy;
  logic accept;
  logic period_end;
  logic last_period;
  logic sel_neg;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy <= 1'b0;
    else if (accept)                    busy <= 1'b1;
    else if (period_end && last_period) busy <= 1'b0;
  end

  runup_period_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .len_in(period_len), .period_end(period_end)
  );

  runup_ref_select u_sel (
    .clk(clk), .rst_n(rst_n), .load(accept), .period_end(period_end),
    .comp(comp), .sel_neg(sel_neg)
  );

  runup_tally #(.NUM_PERIODS(NUM_PERIODS), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .load(accept), .period_end(period_end),
    .sel_neg(sel_neg), .np_cnt(np_cnt), .nn_cnt(nn_cnt),
    .last_period(last_period), .done(done), .result(result)
  );

  assign in_conn = busy;
  assign ref_pos = busy && !sel_neg;
  assign ref_neg = busy && sel_neg;
endmodule

// File: rtl/runup_balancer_chk.sv
module runup_balancer_chk #(
  parameter int NUM_PERIODS = 16,
  parameter int CNT_W       = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_conn,
  input logic                  ref_pos,
  input logic                  ref_neg,
  input logic                  period_end,
  input logic [CNT_W-1:0]      np_cnt,
  input logic [CNT_W-1:0]      nn_cnt,
  input logic signed [CNT_W:0] result,
  input logic                  done
);
  // R3
  one_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_pos, ref_neg}) && (in_conn == (ref_pos || ref_neg)));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pos && !period_end) |=> ref_pos);

  // R5
  neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_neg && !period_end) |=> ref_neg);

  // R6
  tally_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_conn |-> (32'(np_cnt) + 32'(nn_cnt) < NUM_PERIODS));

  // R6
  final_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(np_cnt) + 32'(nn_cnt) == NUM_PERIODS));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_conn);

  // R7
  done_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(result) == int'(nn_cnt) - int'(np_cnt)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));
endmodule

bind runup_balancer runup_balancer_chk #(.NUM_PERIODS(NUM_PERIODS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_conn(in_conn), .ref_pos(ref_pos),
  .ref_neg(ref_neg), .period_end(period_end), .np_cnt(np_cnt),
  .nn_cnt(nn_cnt), .result(result), .done(done)
);

// File: tb/runup_balancer_test.sv
module runup_balancer_test;
  localparam int N     = 16;
  localparam int LEN_W = 8;
  localparam int CW    = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] period_len = '0;
  logic comp = 1'b0;
  logic in_conn, ref_pos, ref_neg, done;
  logic [CW-1:0] np_cnt, nn_cnt;
  logic signed [CW:0] result;

  int n_run = 0;
  int n_fail = 0;
  int prev_diff = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  runup_balancer #(.NUM_PERIODS(N), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_len(period_len),
    .comp(comp), .in_conn(in_conn), .ref_pos(ref_pos), .ref_neg(ref_neg),
    .np_cnt(np_cnt), .nn_cnt(nn_cnt), .result(result), .done(done)
  );

  localparam int NV = 6;
  localparam logic [7:0]  VEC_LEN [NV] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd7};
  localparam logic [15:0] VEC_PAT [NV] = '{16'h0000, 16'hFFFF, 16'hAAAA,
                                          16'h0F0F, 16'h8001, 16'h1234};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] len, input logic [15:0] pat, input bit mid_start);
    int L;
    int exp_nn;
    int exp_diff;
    int run_nn;
    L = (len == 8'd0) ? 1 : int'(len);
    exp_nn = $countones(pat);
    exp_diff = 2 * exp_nn - N;
    @(negedge clk);
    start = 1'b1; comp = pat[0]; period_len = len;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    period_len = len ^ 8'h5A;  // R2: changes after start must not matter
    chk(int'(result) == prev_diff, "R7", "result held into new run", int'(result), prev_diff);
    chk(np_cnt == 0 && nn_cnt == 0, "R9", "counts cleared", int'(np_cnt) + int'(nn_cnt), 0);
    run_nn = 0;
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < L; c++) begin
        logic nxt;
        nxt = (k + 1 < N) ? pat[k+1] : 1'b0;
        chk(in_conn && ref_neg == pat[k] && ref_pos == !pat[k], "R4",
            $sformatf("ref_neg in period %0d clk %0d", k, c), int'(ref_neg), int'(pat[k]));
        if (c == 0)
          chk(int'(nn_cnt) == run_nn && int'(np_cnt) == k - run_nn, "R6",
              $sformatf("nn_cnt at period %0d", k), int'(nn_cnt), run_nn);
        // R8: extra start in mid-run
        start = mid_start && k == 3 && c == 0;
        // R4: comparator is opposite of wanted value except on the last clock
        comp = (c == L - 1) ? nxt : !nxt;
        @(posedge clk); @(negedge clk);
      end
      run_nn += int'(pat[k]);
    end
    start = 1'b0;
    chk(!in_conn && !ref_pos && !ref_neg, "R2", "in_conn off after N*L clocks", int'(in_conn), 0);
    chk(done == 1'b1, "R7", "done after last period", int'(done), 1);
    chk(int'(nn_cnt) == exp_nn, "R6", "final nn_cnt", int'(nn_cnt), exp_nn);
    chk(int'(np_cnt) == N - exp_nn, "R6", "final np_cnt", int'(np_cnt), N - exp_nn);
    chk(int'(result) == exp_diff, "R7", "result nn-np", int'(result), exp_diff);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle only", int'(done), 0);
    chk(int'(result) == exp_diff, "R7", "result holds", int'(result), exp_diff);
    prev_diff = exp_diff;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!in_conn && !ref_pos && !ref_neg && !done, "R1", "outputs idle",
        int'({in_conn, ref_pos, ref_neg, done}), 0);
    chk(np_cnt == 0 && nn_cnt == 0 && result == 0, "R1", "counts zero",
        int'(np_cnt) + int'(nn_cnt) + int'(result), 0);

    for (int v = 0; v < NV; v++) run_vec(VEC_LEN[v], VEC_PAT[v], 1'b0);

    // R2: length 0 acts as 1
    run_vec(8'd0, 16'hC3A5, 1'b0);
    // R8: start during a run is ignored
    run_vec(8'd3, 16'h6B1D, 1'b1);

    // R3: idle with comparator toggling, no reference selected
    comp = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ref_pos && !ref_neg && !in_conn, "R3", "no reference when idle",
        int'({ref_pos, ref_neg}), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule